// File: doc/BRIEF.md
# TDM Slot-Table Circuit Switch

This block is the guaranteed-throughput datapath of a router. Time is cut into slots of equal length, each lasting `BLOCK_CYC` clock cycles, and a free-running slot counter steps through `SLOTS` slots before it wraps. Every router in the fabric leaves reset together, so all of them agree on the current slot. In each slot the switch stores at most one block from every input. A block is `BLOCK_CYC` beats, one beat per cycle. In the following slot it replays each stored block to the outputs chosen by a programmable slot table.

The slot table has one row per slot and one entry per output. Each entry holds an enable bit and the index of an input. Because the table settles contention in advance, a guaranteed block moves exactly one router per slot with no arbitration. Any output beat that the table does not claim is handed to best-effort traffic through a per-output valid/ready side port. An output beat is unclaimed when its entry is disabled, or when its entry is enabled but the selected input delivered no valid beat. Software rewrites entries at run time through a single-cycle write port.

Top module: `tdm_circuit_switch`

## Requirements
- R1: While reset is held, and in the first cycle after it, `slot_o` is 0, `slot_start_o` is 1, no output carries guaranteed data, every `be_ready_o` bit is 1, and the table entries are all disabled.
- R2: Every slot lasts exactly `BLOCK_CYC` cycles. `slot_start_o` is 1 only in the first cycle of a slot, and `slot_o` holds its value for the whole slot, then advances by one.
- R3: A beat driven on input i at beat position k of slot s leaves every output o whose entry in row (s+1) mod `SLOTS` is enabled with source i. It leaves at beat position k of slot s+1, exactly `BLOCK_CYC` cycles later, with `out_gt_o[o]`=1 and the same data.
- R4: Several outputs may name the same input in one row, and each of them receives its own copy of that block.
- R5: If the selected input's beat was captured with its valid low, that output beat is not guaranteed: `out_gt_o` is 0 and the cycle goes to best-effort traffic.
- R6: An output whose entry in the current row is disabled never asserts `out_gt_o`.
- R7: Guaranteed data takes precedence. When `out_gt_o[o]` is 1, `be_ready_o[o]` is 0, and `out_data_o` carries the guaranteed beat whatever `be_valid_i` and `be_data_i` are.
- R8: When output o carries no guaranteed beat, `be_ready_o[o]` is 1, `out_valid_o[o]` equals `be_valid_i[o]`, and `out_data_o` carries `be_data_i` for that port.
- R9: A write (`cfg_we_i`=1) to row r, output `cfg_port_i`, takes effect from the next start of slot r. A write made in the last cycle before slot r begins already applies to it. A write to the row that is active now does not change the rest of the current slot.
- R10: The counter wraps from `SLOTS`-1 to 0, and slot 0 forwards the blocks captured in slot `SLOTS`-1 according to row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gt_valid_i | input | PORTS | Per-input beat valid for guaranteed traffic |
| gt_data_i | input | PORTS*DATA_W | Per-input beat data, input i at bits [i*DATA_W +: DATA_W] |
| be_valid_i | input | PORTS | Per-output best-effort beat offered |
| be_data_i | input | PORTS*DATA_W | Per-output best-effort data |
| be_ready_o | output | PORTS | Output free for best-effort in this cycle |
| out_valid_o | output | PORTS | Output beat valid |
| out_gt_o | output | PORTS | Output beat is guaranteed traffic |
| out_data_o | output | PORTS*DATA_W | Output beat data |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_row_i | input | SLOT_W | Table row (slot) to write |
| cfg_port_i | input | SRC_W | Output column to write |
| cfg_en_i | input | 1 | Enable bit written to the entry |
| cfg_src_i | input | SRC_W | Input index written to the entry |
| slot_o | output | SLOT_W | Current slot number |
| slot_start_o | output | 1 | First cycle of the current slot |

## Verification
The assertions assume that the best-effort side treats `be_ready_o` as a per-cycle grant and accepts that its offered beat may be refused at any time. They also assume that configuration rows and ports stay inside the table. The stimulus only writes rows below `SLOTS` and ports below `PORTS`. It drives all inputs half a cycle away from the clock edge, and it varies the best-effort valid freely, so precedence is exercised in both directions. Table writes are placed mid-slot on the active row and on the final beat before the target slot, to cover both timing cases of R9.

// File: rtl/tdm_sw_pkg.sv
package tdm_sw_pkg;
  typedef enum logic [1:0] {
    OSEL_IDLE = 2'd0,
    OSEL_GT   = 2'd1,
    OSEL_BE   = 2'd2
  } osel_e;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int SLOTS     = 8,
  parameter int BLOCK_CYC = 4,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BEAT_W   = (BLOCK_CYC > 1) ? $clog2(BLOCK_CYC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [BEAT_W-1:0] beat_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] next_slot_o,
  output logic              boundary_o,
  output logic              slot_start_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BLOCK_CYC - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [BEAT_W-1:0] beat_q;
  logic [SLOT_W-1:0] slot_q;

  assign boundary_o   = (beat_q == LAST_BEAT);
  assign next_slot_o  = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
  assign beat_o       = beat_q;
  assign slot_o       = slot_q;
  assign slot_start_o = (beat_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      slot_q <= '0;
    end else if (boundary_o) begin
      beat_q <= '0;
      slot_q <= next_slot_o;
    end else begin
      beat_q <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
  parameter int SLOTS   = 8,
  parameter int PORTS   = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int SRC_W  = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SLOT_W-1:0] cfg_row_i,
  input  logic [SRC_W-1:0]  cfg_port_i,
  input  logic              cfg_en_i,
  input  logic [SRC_W-1:0]  cfg_src_i,
  input  logic              boundary_i,
  input  logic [SLOT_W-1:0] next_slot_i,
  output logic [PORTS-1:0]  act_en_o,
  output logic [SRC_W-1:0]  act_src_o [PORTS]
);
  logic [PORTS-1:0] tab_en_q  [SLOTS];
  logic [SRC_W-1:0] tab_src_q [SLOTS][PORTS];
  logic             wr_ok;
  logic [PORTS-1:0] hit;

  assign wr_ok = cfg_we_i
               && ({1'b0, cfg_row_i} < (SLOT_W+1)'(SLOTS))
               && ({1'b0, cfg_port_i} < (SRC_W+1)'(PORTS));

  // same-cycle write to the row about to start is seen by the snapshot
  always_comb begin
    for (int o = 0; o < PORTS; o++) begin
      hit[o] = wr_ok && (cfg_row_i == next_slot_i) && (cfg_port_i == SRC_W'(o));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < SLOTS; r++) begin
        tab_en_q[r] <= '0;
        for (int o = 0; o < PORTS; o++) tab_src_q[r][o] <= '0;
      end
    end else if (wr_ok) begin
      tab_en_q[cfg_row_i][cfg_port_i]  <= cfg_en_i;
      tab_src_q[cfg_row_i][cfg_port_i] <= cfg_src_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_o <= '0;
      for (int o = 0; o < PORTS; o++) act_src_o[o] <= '0;
    end else if (boundary_i) begin
      for (int o = 0; o < PORTS; o++) begin
        act_en_o[o]  <= hit[o] ? cfg_en_i  : tab_en_q[next_slot_i][o];
        act_src_o[o] <= hit[o] ? cfg_src_i : tab_src_q[next_slot_i][o];
      end
    end
  end
endmodule

// File: rtl/tdm_block_buf.sv
module tdm_block_buf #(
  parameter int BLOCK_CYC = 4,
  parameter int DATA_W    = 32,
  localparam int BEAT_W   = (BLOCK_CYC > 1) ? $clog2(BLOCK_CYC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              boundary_i,
  output logic              fwd_valid_o,
  output logic [DATA_W-1:0] fwd_data_o
);
  logic [DATA_W-1:0]    cap_d [BLOCK_CYC];
  logic [BLOCK_CYC-1:0] cap_v;
  logic [DATA_W-1:0]    fwd_d [BLOCK_CYC];
  logic [BLOCK_CYC-1:0] fwd_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_v <= '0;
      fwd_v <= '0;
      for (int k = 0; k < BLOCK_CYC; k++) begin
        cap_d[k] <= '0;
        fwd_d[k] <= '0;
      end
    end else begin
      cap_d[beat_i] <= in_data_i;
      cap_v[beat_i] <= in_valid_i;
      if (boundary_i) begin
        // last beat bypasses the capture store
        for (int k = 0; k < BLOCK_CYC; k++) begin
          fwd_d[k] <= (k == BLOCK_CYC - 1) ? in_data_i  : cap_d[k];
          fwd_v[k] <= (k == BLOCK_CYC - 1) ? in_valid_i : cap_v[k];
        end
      end
    end
  end

  assign fwd_valid_o = fwd_v[beat_i];
  assign fwd_data_o  = fwd_d[beat_i];
endmodule

// File: rtl/tdm_out_port.sv
module tdm_out_port
  import tdm_sw_pkg::*;
#(
  parameter int PORTS  = 4,
  parameter int DATA_W = 32,
  localparam int SRC_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                    act_en_i,
  input  logic [SRC_W-1:0]        act_src_i,
  input  logic [PORTS-1:0]        buf_valid_i,
  input  logic [PORTS*DATA_W-1:0] buf_data_i,
  input  logic                    be_valid_i,
  input  logic [DATA_W-1:0]       be_data_i,
  output logic                    be_ready_o,
  output logic                    out_valid_o,
  output logic                    out_gt_o,
  output logic [DATA_W-1:0]       out_data_o
);
  logic              gt_vld;
  logic [DATA_W-1:0] gt_word;
  osel_e             sel;

  always_comb begin
    gt_vld  = 1'b0;
    gt_word = '0;
    for (int k = 0; k < PORTS; k++) begin
      if (act_src_i == SRC_W'(k)) begin
        gt_vld  = buf_valid_i[k];
        gt_word = buf_data_i[k*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    if (act_en_i && gt_vld)  sel = OSEL_GT;
    else if (be_valid_i)     sel = OSEL_BE;
    else                     sel = OSEL_IDLE;
  end

  always_comb begin
    unique case (sel)
      OSEL_GT: out_data_o = gt_word;
      OSEL_BE: out_data_o = be_data_i;
      default: out_data_o = '0;
    endcase
  end

  assign out_gt_o    = (sel == OSEL_GT);
  assign out_valid_o = (sel != OSEL_IDLE);
  assign be_ready_o  = (sel != OSEL_GT);
endmodule

// File: rtl/tdm_circuit_switch.sv
module tdm_circuit_switch #(
  parameter int PORTS     = 4,
  parameter int DATA_W    = 32,
  parameter int SLOTS     = 8,
  parameter int BLOCK_CYC = 4,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int SRC_W    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PORTS-1:0]        gt_valid_i,
  input  logic [PORTS*DATA_W-1:0] gt_data_i,
  input  logic [PORTS-1:0]        be_valid_i,
  input  logic [PORTS*DATA_W-1:0] be_data_i,
  output logic [PORTS-1:0]        be_ready_o,
  output logic [PORTS-1:0]        out_valid_o,
  output logic [PORTS-1:0]        out_gt_o,
  output logic [PORTS*DATA_W-1:0] out_data_o,
  input  logic                    cfg_we_i,
  input  logic [SLOT_W-1:0]       cfg_row_i,
  input  logic [SRC_W-1:0]        cfg_port_i,
  input  logic                    cfg_en_i,
  input  logic [SRC_W-1:0]        cfg_src_i,
  output logic [SLOT_W-1:0]       slot_o,
  output logic                    slot_start_o
);
  localparam int BEAT_W = (BLOCK_CYC > 1) ? $clog2(BLOCK_CYC) : 1;

  logic [BEAT_W-1:0]       beat;
  logic [SLOT_W-1:0]       next_slot;
  logic                    boundary;
  logic [PORTS-1:0]        act_en;
  logic [SRC_W-1:0]        act_src [PORTS];
  logic [PORTS-1:0]        buf_valid;
  logic [PORTS*DATA_W-1:0] buf_data;

  tdm_slot_timer #(.SLOTS(SLOTS), .BLOCK_CYC(BLOCK_CYC)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_o       (beat),
    .slot_o       (slot_o),
    .next_slot_o  (next_slot),
    .boundary_o   (boundary),
    .slot_start_o (slot_start_o)
  );

  tdm_slot_table #(.SLOTS(SLOTS), .PORTS(PORTS)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_row_i   (cfg_row_i),
    .cfg_port_i  (cfg_port_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_src_i   (cfg_src_i),
    .boundary_i  (boundary),
    .next_slot_i (next_slot),
    .act_en_o    (act_en),
    .act_src_o   (act_src)
  );

  for (genvar i = 0; i < PORTS; i++) begin : g_in
    tdm_block_buf #(.BLOCK_CYC(BLOCK_CYC), .DATA_W(DATA_W)) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .in_valid_i  (gt_valid_i[i]),
      .in_data_i   (gt_data_i[i*DATA_W +: DATA_W]),
      .beat_i      (beat),
      .boundary_i  (boundary),
      .fwd_valid_o (buf_valid[i]),
      .fwd_data_o  (buf_data[i*DATA_W +: DATA_W])
    );
  end

  for (genvar o = 0; o < PORTS; o++) begin : g_out
    tdm_out_port #(.PORTS(PORTS), .DATA_W(DATA_W)) u_port (
      .act_en_i    (act_en[o]),
      .act_src_i   (act_src[o]),
      .buf_valid_i (buf_valid),
      .buf_data_i  (buf_data),
      .be_valid_i  (be_valid_i[o]),
      .be_data_i   (be_data_i[o*DATA_W +: DATA_W]),
      .be_ready_o  (be_ready_o[o]),
      .out_valid_o (out_valid_o[o]),
      .out_gt_o    (out_gt_o[o]),
      .out_data_o  (out_data_o[o*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/tdm_circuit_switch_chk.sv
module tdm_circuit_switch_chk #(
  parameter int PORTS   = 4,
  parameter int DATA_W  = 32,
  parameter int SLOTS   = 8,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [SLOT_W-1:0]       slot_o,
  input logic                    slot_start_o,
  input logic [PORTS-1:0]        be_valid_i,
  input logic [PORTS*DATA_W-1:0] be_data_i,
  input logic [PORTS-1:0]        be_ready_o,
  input logic [PORTS-1:0]        out_valid_o,
  input logic [PORTS-1:0]        out_gt_o,
  input logic [PORTS*DATA_W-1:0] out_data_o,
  input logic [PORTS-1:0]        act_en_i
);
  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_start_o |-> $stable(slot_o)); // R2
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_o && slot_o != '0) |-> (slot_o == ($past(slot_o) + 1'b1))); // R2
  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_o && $past(slot_o) == SLOT_W'(SLOTS - 1)) |-> (slot_o == '0)); // R10
  AST_ROW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_start_o |-> $stable(act_en_i)); // R9

  for (genvar o = 0; o < PORTS; o++) begin : g_port
    AST_GT_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_gt_o[o] |-> act_en_i[o]); // R6
    AST_GT_OVER_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_gt_o[o] |-> (!be_ready_o[o] && out_valid_o[o])); // R7
    AST_BE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      be_ready_o[o] |-> (!out_gt_o[o] && out_valid_o[o] == be_valid_i[o]
        && (!be_valid_i[o] || out_data_o[o*DATA_W +: DATA_W] == be_data_i[o*DATA_W +: DATA_W]))); // R8
  end
endmodule

bind tdm_circuit_switch tdm_circuit_switch_chk #(
  .PORTS(PORTS), .DATA_W(DATA_W), .SLOTS(SLOTS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_o       (slot_o),
  .slot_start_o (slot_start_o),
  .be_valid_i   (be_valid_i),
  .be_data_i    (be_data_i),
  .be_ready_o   (be_ready_o),
  .out_valid_o  (out_valid_o),
  .out_gt_o     (out_gt_o),
  .out_data_o   (out_data_o),
  .act_en_i     (act_en)
);

// File: tb/tdm_circuit_switch_bench.sv
module tdm_circuit_switch_bench;
  localparam int P = 4;
  localparam int W = 32;
  localparam int S = 8;
  localparam int B = 4;
  localparam int SW = 3;
  localparam int PW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [P-1:0]   gt_valid, be_valid, be_ready, out_valid, out_gt;
  logic [P*W-1:0] gt_data, be_data, out_data;
  logic           cfg_we, cfg_en;
  logic [SW-1:0]  cfg_row, slot;
  logic [PW-1:0]  cfg_port, cfg_src;
  logic           slot_start;

  tdm_circuit_switch #(.PORTS(P), .DATA_W(W), .SLOTS(S), .BLOCK_CYC(B)) u_tdm_circuit_switch (
    .clk_i(clk), .rst_ni(rst_n),
    .gt_valid_i(gt_valid), .gt_data_i(gt_data),
    .be_valid_i(be_valid), .be_data_i(be_data), .be_ready_o(be_ready),
    .out_valid_o(out_valid), .out_gt_o(out_gt), .out_data_o(out_data),
    .cfg_we_i(cfg_we), .cfg_row_i(cfg_row), .cfg_port_i(cfg_port),
    .cfg_en_i(cfg_en), .cfg_src_i(cfg_src),
    .slot_o(slot), .slot_start_o(slot_start)
  );

  int n_run = 0;
  int n_fail = 0;
  int total_cyc = 0;
  string phase = "R3";
  int be_pct = 0;
  int gt_pct = 100;

  // reference model state
  int  m_beat, m_slot;
  bit  m_act_en [P];
  int  m_act_src [P];
  bit  m_tab_en [S][P];
  int  m_tab_src [S][P];
  typedef struct {
    logic [P-1:0]   v;
    logic [P*W-1:0] d;
  } beat_t;
  beat_t hist[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, total_cyc);
    end
  endtask

  task automatic model_reset();
    m_beat = 0; m_slot = 0;
    for (int o = 0; o < P; o++) begin m_act_en[o] = 0; m_act_src[o] = 0; end
    for (int r = 0; r < S; r++) for (int o = 0; o < P; o++) begin
      m_tab_en[r][o] = 0; m_tab_src[r][o] = 0;
    end
    hist.delete();
    for (int k = 0; k < B; k++) begin
      beat_t e; e.v = '0; e.d = '0; hist.push_back(e);
    end
  endtask

  task automatic compare();
    string stag;
    stag = (m_slot == 0 && m_beat == 0 && total_cyc > B) ? "R10" : "R2";
    check(slot == SW'(m_slot), stag, "slot_o", 64'(slot), 64'(m_slot));
    check(slot_start == (m_beat == 0), "R2", "slot_start_o", 64'(slot_start), 64'(m_beat == 0));
    for (int o = 0; o < P; o++) begin
      bit gt;
      logic [W-1:0] ed;
      string tag;
      gt = m_act_en[o] && hist[0].v[m_act_src[o]];
      ed = gt ? hist[0].d[m_act_src[o]*W +: W] : be_data[o*W +: W];
      if (gt && be_valid[o]) tag = "R7";
      else if (!gt && be_valid[o]) tag = "R8";
      else if (!gt && m_act_en[o]) tag = "R5";
      else if (!gt) tag = "R6";
      else tag = phase;
      check(out_gt[o] == gt, tag, $sformatf("out_gt[%0d]", o), 64'(out_gt[o]), 64'(gt));
      check(be_ready[o] == !gt, tag, $sformatf("be_ready[%0d]", o), 64'(be_ready[o]), 64'(!gt));
      check(out_valid[o] == (gt || be_valid[o]), tag, $sformatf("out_valid[%0d]", o),
            64'(out_valid[o]), 64'(gt || be_valid[o]));
      if (gt || be_valid[o])
        check(out_data[o*W +: W] == ed, tag, $sformatf("out_data[%0d]", o),
              64'(out_data[o*W +: W]), 64'(ed));
    end
  endtask

  task automatic model_edge();
    beat_t e;
    if (cfg_we) begin
      m_tab_en[cfg_row][cfg_port]  = cfg_en;
      m_tab_src[cfg_row][cfg_port] = int'(cfg_src);
    end
    e.v = gt_valid; e.d = gt_data;
    hist.push_back(e);
    void'(hist.pop_front());
    if (m_beat == B - 1) begin
      m_beat = 0;
      m_slot = (m_slot + 1) % S;
      for (int o = 0; o < P; o++) begin
        m_act_en[o]  = m_tab_en[m_slot][o];
        m_act_src[o] = m_tab_src[m_slot][o];
      end
    end else begin
      m_beat++;
    end
  endtask

  task automatic drive_traffic();
    for (int i = 0; i < P; i++) begin
      gt_valid[i] = (($urandom % 100) < gt_pct);
      gt_data[i*W +: W] = $urandom;
      be_valid[i] = (($urandom % 100) < be_pct);
      be_data[i*W +: W] = $urandom;
    end
  endtask

  // one clock: inputs already driven after negedge
  task automatic step();
    #1;
    compare();
    @(posedge clk);
    model_edge();
    total_cyc++;
    @(negedge clk);
    cfg_we = 1'b0;
    drive_traffic();
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) step();
  endtask

  task automatic cfg_write(input int row, input int port, input bit en, input int src);
    cfg_we = 1'b1; cfg_row = SW'(row); cfg_port = PW'(port);
    cfg_en = en; cfg_src = PW'(src);
    step();
  endtask

  task automatic wait_pos(input int s, input int b);
    for (int c = 0; c < 4 * S * B; c++) begin
      if (m_slot == s && m_beat == b) break;
      step();
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    gt_valid = '0; gt_data = '0; be_valid = '0; be_data = '0;
    cfg_we = 1'b0; cfg_en = 1'b0; cfg_row = '0; cfg_port = '0; cfg_src = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state while reset held
    check(slot == '0, "R1", "slot_o in reset", 64'(slot), 0);
    check(slot_start == 1'b1, "R1", "slot_start_o in reset", 64'(slot_start), 1);
    check(out_gt == '0, "R1", "out_gt_o in reset", 64'(out_gt), 0);
    check(out_valid == '0, "R1", "out_valid_o in reset", 64'(out_valid), 0);
    check(be_ready == '1, "R1", "be_ready_o in reset", 64'(be_ready), 64'({P{1'b1}}));
    rst_n = 1'b1;
    drive_traffic();

    // R1: table empty after reset, all traffic goes best-effort
    phase = "R1"; be_pct = 50;
    run(S * B);
    check(out_gt == '0, "R1", "no gt with empty table", 64'(out_gt), 0);

    // R3: permutation in every row
    phase = "R3"; be_pct = 0; gt_pct = 100;
    for (int r = 0; r < S; r++)
      for (int o = 0; o < P; o++) cfg_write(r, o, 1'b1, (o + 1 + r) % P);
    run(3 * S * B);

    // R4: multicast row
    phase = "R4";
    for (int o = 0; o < P; o++) cfg_write(3, o, 1'b1, 2);
    run(2 * S * B);

    // R5: sparse guaranteed valids
    phase = "R5"; gt_pct = 50; be_pct = 40;
    run(3 * S * B);

    // R6: disabled entries
    phase = "R6"; gt_pct = 90; be_pct = 60;
    cfg_write(5, 0, 1'b0, 0);
    for (int o = 0; o < P; o++) cfg_write(6, o, 1'b0, o);
    run(2 * S * B);

    // R7 / R8: heavy best-effort pressure against guaranteed traffic
    phase = "R7"; gt_pct = 100; be_pct = 100;
    run(2 * S * B);

    // R9: write to the active row mid-slot, then on the last beat before a row
    phase = "R9"; be_pct = 30;
    wait_pos(2, 1);
    cfg_write(2, 1, 1'b1, 3);
    cfg_write(2, 2, 1'b0, 0);
    run(S * B);
    wait_pos(3, B - 1);
    cfg_write(4, 0, 1'b1, 1);
    run(2 * S * B);

    // R10: wrap boundary with distinct sources on row 0
    phase = "R10"; gt_pct = 100; be_pct = 20;
    for (int o = 0; o < P; o++) cfg_write(0, o, 1'b1, P - 1 - o);
    wait_pos(S - 1, 0);
    run(3 * S * B);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule